// File: doc/BRIEF.md
# Converter Power-Up Sequencer with Soft-Start Setpoint

This block brings a switching converter controller out of power-up in an orderly way. A digitized supply level is compared against two thresholds with hysteresis. Once the supply has climbed high enough, a fixed wait runs while the gate drive stays off and the soft-start accumulator is pinned at zero. When the wait ends, the drive is enabled and the accumulator climbs by a configurable increment at a fixed cadence until it saturates at full scale.

The peak-current setpoint handed to the current comparator is one third of the smaller of the accumulator and an external override code. Holding the override low gives analog dimming. A one-cycle pulse is issued each time the supply leaves undervoltage; downstream fault latches clear only on that pulse, so a full supply cycle is the only way out of a latched fault. A digitized die temperature that stays hot for a qualifying interval turns the drive off until it has cooled by a hysteresis margin.

Top module: `startup_sequencer`

## Requirements
- R1: While reset is high and on the first cycle after it, `drv_en`, `setpoint` and `latch_clr` are all 0.
- R2: The supply is released from undervoltage when `sup_code >= ON_CODE` and returns to undervoltage when `sup_code < OFF_CODE`; between the two thresholds the current state is kept.
- R3: `latch_clr` is high for exactly one cycle, in the cycle after a clock edge at which the supply leaves undervoltage, and is low at all other times.
- R4: For `DELAY_CYC` clock cycles after release the accumulator stays at 0 and `drv_en` stays 0.
- R5: After the delay the accumulator adds `step_cfg` once every `STEP_DIV` cycles and saturates at `3*LIM_CODE`; it never decreases while running.
- R6: `drv_en` is registered and is 1 only when the ramp phase is active, the supply is released and no over-temperature condition is active.
- R7: `setpoint` is registered and equals floor(min(accumulator, `ovr_code`) / 3).
- R8: Falling into undervoltage at any time clears the accumulator, turns the drive off and re-arms the full startup delay.
- R9: Over-temperature becomes active only after `OT_DLY` consecutive samples with `temp_code >= TRIP_CODE`, and clears once `temp_code < TRIP_CODE - HYS_CODE`.
- R10: With `step_cfg` equal to 0 the accumulator holds its value while the drive is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_code | input | SUP_W | Digitized supply level |
| temp_code | input | TMP_W | Digitized die temperature |
| step_cfg | input | STEP_W | Accumulator increment per step |
| ovr_code | input | RAMP_W | External override for the accumulator (analog dimming) |
| drv_en | output | 1 | Gate drive permitted |
| setpoint | output | RAMP_W | Peak-current setpoint code |
| latch_clr | output | 1 | One-cycle clear pulse for fault latches |

## Verification
A stuck or misloaded delay counter shows as `drv_en` rising at the wrong cycle after the release pulse, visible within one delay interval. A wrong accumulator value appears in `setpoint` one cycle later, and the per-clock comparison with the behavioural model catches any drift at the first step where it would differ. A hysteresis state that is lost or wrongly kept shows as a missing or spurious `latch_clr` pulse, or as drive coming back while the supply sits between the thresholds. A wrong over-temperature qualification changes `drv_en` within `OT_DLY` cycles of the hot interval.

// File: rtl/startup_pkg.sv
package startup_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DELAY = 2'd1,
    PH_RAMP  = 2'd2
  } seq_phase_e;

endpackage

// File: rtl/supply_monitor.sv
module supply_monitor #(
  parameter int SUP_W    = 10,
  parameter int ON_CODE  = 500,
  parameter int OFF_CODE = 440
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SUP_W-1:0] sup_code,
  output logic             uv_ok,
  output logic             rel_pulse
);

  localparam logic [SUP_W-1:0] ON_L  = SUP_W'(ON_CODE);
  localparam logic [SUP_W-1:0] OFF_L = SUP_W'(OFF_CODE);

  logic above_on;
  logic below_off;

  assign above_on  = (sup_code >= ON_L);
  assign below_off = (sup_code < OFF_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      uv_ok     <= 1'b0;
      rel_pulse <= 1'b0;
    end else begin
      rel_pulse <= ~uv_ok & above_on;
      if (!uv_ok && above_on) begin
        uv_ok <= 1'b1;
      end else if (uv_ok && below_off) begin
        uv_ok <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/thermal_guard.sv
module thermal_guard #(
  parameter int TMP_W     = 8,
  parameter int TRIP_CODE = 200,
  parameter int HYS_CODE  = 40,
  parameter int OT_DLY    = 75
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TMP_W-1:0] temp_code,
  output logic             ot_act
);

  localparam int CNT_W = (OT_DLY > 1) ? $clog2(OT_DLY) : 1;
  localparam logic [TMP_W-1:0] TRIP_L = TMP_W'(TRIP_CODE);
  localparam logic [TMP_W-1:0] REL_L  = TMP_W'(TRIP_CODE - HYS_CODE);
  localparam logic [CNT_W-1:0] LAST_L = CNT_W'(OT_DLY - 1);

  logic [CNT_W-1:0] hot_cnt;
  logic             hot;
  logic             cool;

  assign hot  = (temp_code >= TRIP_L);
  assign cool = (temp_code < REL_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      ot_act  <= 1'b0;
      hot_cnt <= '0;
    end else if (!ot_act) begin
      if (hot) begin
        if (hot_cnt == LAST_L) begin
          ot_act  <= 1'b1;
          hot_cnt <= '0;
        end else begin
          hot_cnt <= hot_cnt + 1'b1;
        end
      end else begin
        hot_cnt <= '0;
      end
    end else if (cool) begin
      ot_act  <= 1'b0;
      hot_cnt <= '0;
    end
  end

endmodule

// File: rtl/softstart_ramp.sv
module softstart_ramp
  import startup_pkg::*;
#(
  parameter int RAMP_W    = 12,
  parameter int RAMP_MAX  = 3000,
  parameter int STEP_W    = 6,
  parameter int DELAY_CYC = 130000,
  parameter int STEP_DIV  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              uv_ok,
  input  logic [STEP_W-1:0] step_cfg,
  output logic [RAMP_W-1:0] ramp,
  output logic              running
);

  localparam int DLY_W = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
  localparam int DIV_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [DLY_W-1:0]  DLY_LAST = DLY_W'(DELAY_CYC - 1);
  localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(STEP_DIV - 1);
  localparam logic [RAMP_W:0]   MAX_X    = (RAMP_W+1)'(RAMP_MAX);

  seq_phase_e        phase;
  logic [DLY_W-1:0]  dly_cnt;
  logic [DIV_W-1:0]  div_cnt;
  logic [RAMP_W:0]   sum;
  logic [RAMP_W-1:0] ramp_sat;

  assign sum      = {1'b0, ramp} + {{(RAMP_W+1-STEP_W){1'b0}}, step_cfg};
  assign ramp_sat = (sum >= MAX_X) ? MAX_X[RAMP_W-1:0] : sum[RAMP_W-1:0];
  assign running  = (phase == PH_RAMP);

  always_ff @(posedge clk) begin
    if (rst || !uv_ok) begin
      phase   <= PH_IDLE;
      dly_cnt <= '0;
      div_cnt <= '0;
      ramp    <= '0;
    end else begin
      case (phase)
        PH_IDLE, PH_DELAY: begin
          if (dly_cnt == DLY_LAST) begin
            phase   <= PH_RAMP;
            dly_cnt <= '0;
          end else begin
            phase   <= PH_DELAY;
            dly_cnt <= dly_cnt + 1'b1;
          end
        end
        PH_RAMP: begin
          if (div_cnt == DIV_LAST) begin
            div_cnt <= '0;
            ramp    <= ramp_sat;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer #(
  parameter int SUP_W     = 10,
  parameter int ON_CODE   = 500,
  parameter int OFF_CODE  = 440,
  parameter int TMP_W     = 8,
  parameter int TRIP_CODE = 200,
  parameter int HYS_CODE  = 40,
  parameter int OT_DLY    = 75,
  parameter int LIM_CODE  = 1000,
  parameter int STEP_W    = 6,
  parameter int DELAY_CYC = 130000,
  parameter int STEP_DIV  = 64,
  parameter int RAMP_MAX  = 3 * LIM_CODE,
  parameter int RAMP_W    = $clog2(RAMP_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SUP_W-1:0]  sup_code,
  input  logic [TMP_W-1:0]  temp_code,
  input  logic [STEP_W-1:0] step_cfg,
  input  logic [RAMP_W-1:0] ovr_code,
  output logic              drv_en,
  output logic [RAMP_W-1:0] setpoint,
  output logic              latch_clr
);

  localparam logic [RAMP_W-1:0] DIVISOR = RAMP_W'(3);

  logic              uv_ok;
  logic              running;
  logic              ot_act;
  logic [RAMP_W-1:0] ramp;
  logic [RAMP_W-1:0] lim_val;

  supply_monitor #(
    .SUP_W   (SUP_W),
    .ON_CODE (ON_CODE),
    .OFF_CODE(OFF_CODE)
  ) i_supply (
    .clk      (clk),
    .rst      (rst),
    .sup_code (sup_code),
    .uv_ok    (uv_ok),
    .rel_pulse(latch_clr)
  );

  thermal_guard #(
    .TMP_W    (TMP_W),
    .TRIP_CODE(TRIP_CODE),
    .HYS_CODE (HYS_CODE),
    .OT_DLY   (OT_DLY)
  ) i_thermal (
    .clk      (clk),
    .rst      (rst),
    .temp_code(temp_code),
    .ot_act   (ot_act)
  );

  softstart_ramp #(
    .RAMP_W   (RAMP_W),
    .RAMP_MAX (RAMP_MAX),
    .STEP_W   (STEP_W),
    .DELAY_CYC(DELAY_CYC),
    .STEP_DIV (STEP_DIV)
  ) i_ramp (
    .clk     (clk),
    .rst     (rst),
    .uv_ok   (uv_ok),
    .step_cfg(step_cfg),
    .ramp    (ramp),
    .running (running)
  );

  assign lim_val = (ovr_code < ramp) ? ovr_code : ramp;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_en   <= 1'b0;
      setpoint <= '0;
    end else begin
      drv_en   <= running & uv_ok & ~ot_act;
      setpoint <= lim_val / DIVISOR;
    end
  end

endmodule

// File: rtl/startup_sequencer_chk.sv
module startup_sequencer_chk #(
  parameter int RAMP_W   = 12,
  parameter int RAMP_MAX = 3000
) (
  input logic              clk,
  input logic              rst,
  input logic              drv_en,
  input logic [RAMP_W-1:0] setpoint,
  input logic              latch_clr,
  input logic              uv_ok,
  input logic              running,
  input logic              ot_act,
  input logic [RAMP_W-1:0] ramp
);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    latch_clr |=> !latch_clr); // R3

  AST_PULSE_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(uv_ok) |-> latch_clr); // R3

  AST_DELAY_RAMP_ZERO: assert property (@(posedge clk) disable iff (rst)
    !running |-> (ramp == '0)); // R4

  AST_RAMP_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    (running && $past(running)) |-> (ramp >= $past(ramp))); // R5

  AST_RAMP_CAP: assert property (@(posedge clk) disable iff (rst)
    ramp <= RAMP_W'(RAMP_MAX)); // R5

  AST_DRV_OFF_HOT: assert property (@(posedge clk) disable iff (rst)
    ot_act |=> !drv_en); // R6

  AST_SETPOINT_BOUND: assert property (@(posedge clk) disable iff (rst)
    setpoint <= RAMP_W'(RAMP_MAX / 3)); // R7

  AST_UV_ABORT: assert property (@(posedge clk) disable iff (rst)
    $fell(uv_ok) |=> (!running && ramp == '0 && !drv_en)); // R8

endmodule

bind startup_sequencer startup_sequencer_chk #(
  .RAMP_W  (RAMP_W),
  .RAMP_MAX(RAMP_MAX)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .drv_en   (drv_en),
  .setpoint (setpoint),
  .latch_clr(latch_clr),
  .uv_ok    (uv_ok),
  .running  (running),
  .ot_act   (ot_act),
  .ramp     (ramp)
);

// File: tb/test_startup_sequencer.sv
module test_startup_sequencer;

  localparam int SUP_W = 8, ON_C = 200, OFF_C = 176;
  localparam int TMP_W = 8, TRIP_C = 150, HYS_C = 20, OTD = 5;
  localparam int LIM = 100, STW = 4, DLY = 20, DIV = 4;
  localparam int RMAX = 3 * LIM;
  localparam int RW = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SUP_W-1:0] sup_code = '0;
  logic [TMP_W-1:0] temp_code = '0;
  logic [STW-1:0]   step_cfg = 4'd7;
  logic [RW-1:0]    ovr_code = 9'd511;
  logic             drv_en;
  logic [RW-1:0]    setpoint;
  logic             latch_clr;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  startup_sequencer #(
    .SUP_W(SUP_W), .ON_CODE(ON_C), .OFF_CODE(OFF_C),
    .TMP_W(TMP_W), .TRIP_CODE(TRIP_C), .HYS_CODE(HYS_C), .OT_DLY(OTD),
    .LIM_CODE(LIM), .STEP_W(STW), .DELAY_CYC(DLY), .STEP_DIV(DIV)
  ) i_startup_sequencer (
    .clk(clk), .rst(rst), .sup_code(sup_code), .temp_code(temp_code),
    .step_cfg(step_cfg), .ovr_code(ovr_code), .drv_en(drv_en),
    .setpoint(setpoint), .latch_clr(latch_clr)
  );

  // behavioural reference model
  int  m_uv, m_clr, m_dly, m_run, m_ramp, m_div, m_otc, m_ot, m_drv, m_sp;

  always @(posedge clk) begin
    if (rst) begin
      m_uv = 0; m_clr = 0; m_dly = 0; m_run = 0; m_ramp = 0;
      m_div = 0; m_otc = 0; m_ot = 0; m_drv = 0; m_sp = 0;
    end else begin
      int mn;
      int s;
      int t;
      s  = int'(sup_code);
      t  = int'(temp_code);
      mn = (int'(ovr_code) < m_ramp) ? int'(ovr_code) : m_ramp;
      m_drv = (m_run != 0 && m_uv != 0 && m_ot == 0) ? 1 : 0;
      m_sp  = mn / 3;
      m_clr = (m_uv == 0 && s >= ON_C) ? 1 : 0;
      if (m_uv == 0) begin
        m_dly = 0; m_run = 0; m_ramp = 0; m_div = 0;
      end else if (m_run == 0) begin
        if (m_dly == DLY - 1) m_run = 1;
        else m_dly++;
      end else if (m_div == DIV - 1) begin
        m_div = 0;
        m_ramp = m_ramp + int'(step_cfg);
        if (m_ramp > RMAX) m_ramp = RMAX;
      end else begin
        m_div++;
      end
      if (m_uv == 0 && s >= ON_C) m_uv = 1;
      else if (m_uv != 0 && s < OFF_C) m_uv = 0;
      if (m_ot == 0) begin
        if (t >= TRIP_C) begin
          if (m_otc == OTD - 1) begin m_ot = 1; m_otc = 0; end
          else m_otc++;
        end else m_otc = 0;
      end else if (t < TRIP_C - HYS_C) begin
        m_ot = 0; m_otc = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(int'(drv_en) == m_drv, "R6 drv_en vs model", int'(drv_en), m_drv);
      chk(int'(setpoint) == m_sp, "R7 setpoint vs model", int'(setpoint), m_sp);
      chk(int'(latch_clr) == m_clr, "R3 latch_clr vs model", int'(latch_clr), m_clr);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_n(4);
    chk(drv_en == 1'b0, "R1 drv_en in reset", int'(drv_en), 0);
    chk(setpoint == '0, "R1 setpoint in reset", int'(setpoint), 0);
    chk(latch_clr == 1'b0, "R1 latch_clr in reset", int'(latch_clr), 0);
    rst = 1'b0;
    wait_n(1);
    chk(drv_en == 1'b0 && latch_clr == 1'b0, "R1 first cycle", int'(drv_en), 0);

    sup_code = 8'd190;
    wait_n(10);
    chk(latch_clr == 1'b0, "R2 no release between thresholds", int'(latch_clr), 0);
    chk(drv_en == 1'b0, "R2 drive off below on threshold", int'(drv_en), 0);

    sup_code = 8'd200;
    wait_n(1);
    chk(latch_clr == 1'b1, "R3 pulse at release", int'(latch_clr), 1);
    wait_n(1);
    chk(latch_clr == 1'b0, "R3 pulse one cycle", int'(latch_clr), 0);
    wait_n(10);
    chk(drv_en == 1'b0, "R4 drive off during delay", int'(drv_en), 0);
    chk(setpoint == '0, "R4 setpoint zero during delay", int'(setpoint), 0);
    wait_n(200);
    chk(drv_en == 1'b1, "R6 drive on after delay", int'(drv_en), 1);
    chk(setpoint == 9'd100, "R5 saturated setpoint", int'(setpoint), 100);

    ovr_code = 9'd90;
    wait_n(2);
    chk(setpoint == 9'd30, "R7 override lowers setpoint", int'(setpoint), 30);
    ovr_code = 9'd0;
    wait_n(2);
    chk(setpoint == 9'd0, "R7 override zero", int'(setpoint), 0);
    ovr_code = 9'd511;

    sup_code = 8'd177;
    wait_n(5);
    chk(drv_en == 1'b1, "R2 hysteresis keeps release", int'(drv_en), 1);
    sup_code = 8'd175;
    wait_n(3);
    chk(drv_en == 1'b0, "R8 undervoltage drive off", int'(drv_en), 0);
    chk(setpoint == '0, "R8 undervoltage setpoint zero", int'(setpoint), 0);

    step_cfg = 4'd0;
    sup_code = 8'd220;
    wait_n(1);
    chk(latch_clr == 1'b1, "R3 pulse after full cycle", int'(latch_clr), 1);
    wait_n(60);
    chk(drv_en == 1'b1, "R10 drive on with zero step", int'(drv_en), 1);
    chk(setpoint == '0, "R10 zero step holds", int'(setpoint), 0);

    step_cfg = 4'd3;
    wait_n(12);
    chk(setpoint != '0, "R5 ramp climbs", int'(setpoint), 1);
    sup_code = 8'd100;
    wait_n(3);
    chk(drv_en == 1'b0 && setpoint == '0, "R8 abort mid-ramp", int'(setpoint), 0);
    sup_code = 8'd220;
    wait_n(15);
    chk(drv_en == 1'b0, "R8 delay re-armed", int'(drv_en), 0);
    wait_n(30);
    chk(drv_en == 1'b1, "R6 drive after re-armed delay", int'(drv_en), 1);

    temp_code = 8'd150;
    wait_n(OTD - 1);
    temp_code = 8'd100;
    wait_n(3);
    chk(drv_en == 1'b1, "R9 short hot spell ignored", int'(drv_en), 1);
    temp_code = 8'd150;
    wait_n(OTD + 3);
    chk(drv_en == 1'b0, "R9 over-temperature trips", int'(drv_en), 0);
    temp_code = 8'd130;
    wait_n(5);
    chk(drv_en == 1'b0, "R9 hysteresis holds trip", int'(drv_en), 0);
    temp_code = 8'd129;
    wait_n(3);
    chk(drv_en == 1'b1, "R9 release after cooling", int'(drv_en), 1);

    wait_n(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule